// File: doc/BRIEF.md
# I2C Byte Buffers with Threshold Interrupts

This block sits between a register front end and an I2C transaction engine. It holds one byte queue per direction. The transmit queue is filled by the host and drained by the engine. The receive queue is filled by the engine and drained by the host. The block also gathers every interrupt source into a 32-bit raw status word. Queue-level conditions are live flags that follow the queue state. Engine events and transmit overrun are sticky bits that software clears by writing ones.

A 32-bit mask selects which raw bits reach the masked status word. The single interrupt line is the OR of that masked word. Each queue has a 4-bit threshold that places its "nearly empty" or "nearly full" flag.

Each queue also has a flush request. A flush empties the queue at once and then keeps it busy for a fixed number of cycles. The busy flag reads back as 1 until the flush completes, and then clears itself. While a queue is busy, all pushes and pops to it are dropped. The bus protocol itself lives in the engine and is not part of this block.

Top module: `i2c_buf_irq`

## Requirements
- R1: Each queue holds DEPTH (default 16) bytes in first-in first-out order. A push to a full queue or a pop from an empty queue is dropped. The read-side byte (`eng_tx_data`, `host_rx_data`) shows the oldest entry, and `tx_level`/`rx_level` give the entry count one cycle after the push or pop edge.
- R2: The live status bits follow the queue counts in the same cycle as the level: bit 0 is TX empty (level 0), bit 2 is TX full (level DEPTH), bit 4 is RX empty, and bit 6 is RX full.
- R3: Bit 1 (TX nearly empty) is 1 when the TX level is at most `tx_thresh`. Bit 5 (RX nearly full) is 1 when the RX level is at least `rx_thresh`. Both thresholds range from 0 to 15.
- R4: A host push while the TX queue is full and not flushing sets sticky bit 3 (overrun) on the next cycle. The byte is discarded.
- R5: A pulse on `ev_done`, `ev_done_nostop`, `ev_arb_lost` or `ev_bus_err` sets sticky bit 19, 28, 24 or 25 respectively, one cycle later. The bit then stays set.
- R6: A clear write (`clr_wr`) drops each sticky bit whose `clr_wdata` bit is 1, using only the positions in 0x131F007F. Live bits are not affected. If an event and its clear arrive in the same cycle, the bit stays set.
- R7: A flush request empties its queue on the next edge. The matching busy output is then 1 for FLUSH_CYCLES (default 4) cycles and clears itself.
- R8: While a queue's busy output is 1, pushes and pops from both host and engine to that queue are ignored, and no overrun is recorded.
- R9: A mask write stores bits 28:0 of `mask_wdata`. Bits 31:29 of `mask_q` always read 0, and the mask is 0 after reset.
- R10: `masked_status` equals `raw_status` AND `mask_q`. `irq` is 1 exactly when any masked bit is 1.
- R11: After reset both queues are empty, the sticky bits and the mask are 0, and the busy outputs are 0. With `tx_thresh`=2 and `rx_thresh`=3, `raw_status` reads 0x13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_thresh | input | 4 | TX nearly-empty threshold |
| rx_thresh | input | 4 | RX nearly-full threshold |
| host_tx_push | input | 1 | Host writes a byte to the TX queue |
| host_tx_data | input | 8 | Byte written by the host |
| host_rx_pop | input | 1 | Host removes the oldest RX byte |
| host_rx_data | output | 8 | Oldest RX byte |
| eng_tx_pop | input | 1 | Engine removes the oldest TX byte |
| eng_tx_data | output | 8 | Oldest TX byte |
| eng_rx_push | input | 1 | Engine writes a byte to the RX queue |
| eng_rx_data | input | 8 | Byte written by the engine |
| tx_flush_req | input | 1 | Start a TX queue flush |
| rx_flush_req | input | 1 | Start an RX queue flush |
| tx_flush_busy | output | 1 | TX flush in progress |
| rx_flush_busy | output | 1 | RX flush in progress |
| tx_level | output | 5 | TX entry count |
| rx_level | output | 5 | RX entry count |
| ev_done | input | 1 | Engine pulse: transaction finished with stop |
| ev_done_nostop | input | 1 | Engine pulse: transaction finished without stop |
| ev_arb_lost | input | 1 | Engine pulse: arbitration lost |
| ev_bus_err | input | 1 | Engine pulse: misplaced start or stop seen |
| mask_wr | input | 1 | Load the mask register |
| mask_wdata | input | 32 | New mask value |
| mask_q | output | 32 | Current mask |
| clr_wr | input | 1 | Apply a write-one-to-clear |
| clr_wdata | input | 32 | Bits to clear |
| raw_status | output | 32 | Unmasked interrupt status |
| masked_status | output | 32 | Status after the mask |
| irq | output | 1 | Interrupt request |

## Verification
The bound checker watches several rules on every cycle:
- a queue level never exceeds DEPTH;
- a push into a full, idle TX queue always raises the overrun bit;
- an engine pulse always lands in its sticky bit;
- a sticky bit never drops unless a clear write names it;
- a busy queue always reads empty, including on the cycle its busy flag falls.

Some behaviours only the bench scenarios can show:
- byte order through each queue;
- the exact threshold boundaries;
- the length of the busy window;
- event-over-clear priority on a shared cycle;
- the reserved mask bits;
- the interrupt line following the mask.

// File: rtl/i2cbi_pkg.sv
package i2cbi_pkg;
   localparam int STAT_W = 32;

   // status bit positions; the engine-side decoder relies on these
   localparam int BIT_TX_EMPTY  = 0;
   localparam int BIT_TX_NEMPTY = 1;
   localparam int BIT_TX_FULL   = 2;
   localparam int BIT_TX_OVR    = 3;
   localparam int BIT_RX_EMPTY  = 4;
   localparam int BIT_RX_NFULL  = 5;
   localparam int BIT_RX_FULL   = 6;
   localparam int BIT_DONE      = 19;
   localparam int BIT_ARB       = 24;
   localparam int BIT_BERR      = 25;
   localparam int BIT_DONE_NS   = 28;

   localparam logic [STAT_W-1:0] CLEARABLE   = 32'h131F_007F;
   localparam logic [STAT_W-1:0] MASK_IMPL   = 32'h1FFF_FFFF;
   localparam logic [STAT_W-1:0] STICKY_MASK = 32'h1308_0008;
   localparam logic [STAT_W-1:0] LEVEL_MASK  = 32'h0000_0077;
endpackage

// File: rtl/i2cbi_byte_fifo.sv
module i2cbi_byte_fifo #(
   parameter  int DEPTH = 16,
   parameter  int DW    = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int LW    = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] cnt;
   logic          do_push, do_pop;

   assign full    = (cnt == LW'(DEPTH));
   assign empty   = (cnt == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign rdata   = mem[rd_ptr];
   assign level   = cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else if (clear) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + LW'(1);
            2'b01:   cnt <= cnt - LW'(1);
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clear) mem[wr_ptr] <= wdata;
   end
endmodule

// File: rtl/i2cbi_flush_ctl.sv
module i2cbi_flush_ctl #(
   parameter int CYCLES = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic busy
);
   generate
      if (CYCLES <= 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy <= 1'b0;
            else        busy <= req;
         end
      end else begin : g_count
         localparam int CW = $clog2(CYCLES);
         logic [CW-1:0] remain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy   <= 1'b0;
               remain <= '0;
            end else if (req) begin
               busy   <= 1'b1;
               remain <= CW'(CYCLES - 1);
            end else if (busy) begin
               if (remain == '0) busy <= 1'b0;
               else              remain <= remain - CW'(1);
            end
         end
      end
   endgenerate
endmodule

// File: rtl/i2cbi_irq_status.sv
module i2cbi_irq_status
   import i2cbi_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [STAT_W-1:0] level_vec,
   input  logic [STAT_W-1:0] set_vec,
   input  logic              clr_wr,
   input  logic [STAT_W-1:0] clr_wdata,
   input  logic              mask_wr,
   input  logic [STAT_W-1:0] mask_wdata,
   output logic [STAT_W-1:0] raw,
   output logic [STAT_W-1:0] mask_q,
   output logic [STAT_W-1:0] masked,
   output logic              irq
);
   logic [STAT_W-1:0] sticky_q;
   logic [STAT_W-1:0] clr_eff;

   assign clr_eff = clr_wr ? (clr_wdata & CLEARABLE) : '0;

   // set has priority over a clear landing in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sticky_q <= '0;
      else        sticky_q <= ((sticky_q & ~clr_eff) | set_vec) & STICKY_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mask_q <= '0;
      else if (mask_wr) mask_q <= mask_wdata & MASK_IMPL;
   end

   assign raw    = sticky_q | (level_vec & LEVEL_MASK);
   assign masked = raw & mask_q;
   assign irq    = |masked;
endmodule

// File: rtl/i2c_buf_irq.sv
module i2c_buf_irq
   import i2cbi_pkg::*;
#(
   parameter  int DEPTH        = 16,
   parameter  int MAX_TH       = 15,
   parameter  int FLUSH_CYCLES = 4,
   localparam int LW           = $clog2(DEPTH) + 1,
   localparam int TH_W         = $clog2(MAX_TH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TH_W-1:0]   tx_thresh,
   input  logic [TH_W-1:0]   rx_thresh,
   input  logic              host_tx_push,
   input  logic [7:0]        host_tx_data,
   input  logic              host_rx_pop,
   output logic [7:0]        host_rx_data,
   input  logic              eng_tx_pop,
   output logic [7:0]        eng_tx_data,
   input  logic              eng_rx_push,
   input  logic [7:0]        eng_rx_data,
   input  logic              tx_flush_req,
   input  logic              rx_flush_req,
   output logic              tx_flush_busy,
   output logic              rx_flush_busy,
   output logic [LW-1:0]     tx_level,
   output logic [LW-1:0]     rx_level,
   input  logic              ev_done,
   input  logic              ev_done_nostop,
   input  logic              ev_arb_lost,
   input  logic              ev_bus_err,
   input  logic              mask_wr,
   input  logic [STAT_W-1:0] mask_wdata,
   output logic [STAT_W-1:0] mask_q,
   input  logic              clr_wr,
   input  logic [STAT_W-1:0] clr_wdata,
   output logic [STAT_W-1:0] raw_status,
   output logic [STAT_W-1:0] masked_status,
   output logic              irq
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (MAX_TH >= DEPTH) begin : g_bad_th
         $error("MAX_TH must be below DEPTH");
      end
      if (FLUSH_CYCLES < 1) begin : g_bad_flush
         $error("FLUSH_CYCLES must be at least 1");
      end
   endgenerate

   logic tx_full, tx_empty, rx_full, rx_empty;
   logic tx_push_ok, tx_pop_ok, rx_push_ok, rx_pop_ok, tx_ovr;
   logic [STAT_W-1:0] lvl_vec, set_vec;

   // busy queues drop every access, including the overrun record
   assign tx_push_ok = host_tx_push & ~tx_flush_busy;
   assign tx_pop_ok  = eng_tx_pop   & ~tx_flush_busy;
   assign rx_push_ok = eng_rx_push  & ~rx_flush_busy;
   assign rx_pop_ok  = host_rx_pop  & ~rx_flush_busy;
   assign tx_ovr     = tx_push_ok & tx_full;

   i2cbi_flush_ctl #(.CYCLES(FLUSH_CYCLES)) u_tx_flush (
      .clk(clk), .rst_n(rst_n), .req(tx_flush_req), .busy(tx_flush_busy));

   i2cbi_flush_ctl #(.CYCLES(FLUSH_CYCLES)) u_rx_flush (
      .clk(clk), .rst_n(rst_n), .req(rx_flush_req), .busy(rx_flush_busy));

   i2cbi_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_tx_q (
      .clk(clk), .rst_n(rst_n), .clear(tx_flush_req),
      .push(tx_push_ok), .wdata(host_tx_data),
      .pop(tx_pop_ok), .rdata(eng_tx_data),
      .level(tx_level), .full(tx_full), .empty(tx_empty));

   i2cbi_byte_fifo #(.DEPTH(DEPTH), .DW(8)) u_rx_q (
      .clk(clk), .rst_n(rst_n), .clear(rx_flush_req),
      .push(rx_push_ok), .wdata(eng_rx_data),
      .pop(rx_pop_ok), .rdata(host_rx_data),
      .level(rx_level), .full(rx_full), .empty(rx_empty));

   always_comb begin
      lvl_vec                = '0;
      lvl_vec[BIT_TX_EMPTY]  = tx_empty;
      lvl_vec[BIT_TX_NEMPTY] = (tx_level <= LW'(tx_thresh));
      lvl_vec[BIT_TX_FULL]   = tx_full;
      lvl_vec[BIT_RX_EMPTY]  = rx_empty;
      lvl_vec[BIT_RX_NFULL]  = (rx_level >= LW'(rx_thresh));
      lvl_vec[BIT_RX_FULL]   = rx_full;

      set_vec                = '0;
      set_vec[BIT_TX_OVR]    = tx_ovr;
      set_vec[BIT_DONE]      = ev_done;
      set_vec[BIT_DONE_NS]   = ev_done_nostop;
      set_vec[BIT_ARB]       = ev_arb_lost;
      set_vec[BIT_BERR]      = ev_bus_err;
   end

   i2cbi_irq_status u_stat (
      .clk(clk), .rst_n(rst_n),
      .level_vec(lvl_vec), .set_vec(set_vec),
      .clr_wr(clr_wr), .clr_wdata(clr_wdata),
      .mask_wr(mask_wr), .mask_wdata(mask_wdata),
      .raw(raw_status), .mask_q(mask_q),
      .masked(masked_status), .irq(irq));
endmodule

// File: rtl/i2c_buf_irq_chk.sv
module i2c_buf_irq_chk
   import i2cbi_pkg::*;
#(
   parameter  int DEPTH = 16,
   localparam int LW    = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_tx_push,
   input logic [LW-1:0]     tx_level,
   input logic [LW-1:0]     rx_level,
   input logic              tx_busy,
   input logic              rx_busy,
   input logic [STAT_W-1:0] raw_status,
   input logic              clr_wr,
   input logic [STAT_W-1:0] clr_wdata,
   input logic [3:0]        ev_vec
);
   logic [STAT_W-1:0] ev_bits, keep_bits;

   always_comb begin
      ev_bits              = '0;
      ev_bits[BIT_DONE]    = ev_vec[0];
      ev_bits[BIT_DONE_NS] = ev_vec[1];
      ev_bits[BIT_ARB]     = ev_vec[2];
      ev_bits[BIT_BERR]    = ev_vec[3];
      keep_bits = raw_status & STICKY_MASK & ~({STAT_W{clr_wr}} & clr_wdata & CLEARABLE);
   end

   AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH))); // R1

   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (host_tx_push && !tx_busy && tx_level == LW'(DEPTH)) |=> raw_status[BIT_TX_OVR]); // R4

   AST_EVENT_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_vec != '0) |=> ((raw_status & $past(ev_bits)) == $past(ev_bits))); // R5

   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (keep_bits != '0) |=> ((raw_status & $past(keep_bits)) == $past(keep_bits))); // R6

   AST_FLUSH_TX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_busy |-> (tx_level == '0)); // R8

   AST_FLUSH_RX_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      rx_busy |-> (rx_level == '0)); // R8

   AST_FLUSH_END_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> (tx_level == '0)); // R7
endmodule

bind i2c_buf_irq i2c_buf_irq_chk #(.DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_tx_push(host_tx_push),
   .tx_level(tx_level), .rx_level(rx_level),
   .tx_busy(tx_flush_busy), .rx_busy(rx_flush_busy),
   .raw_status(raw_status), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
   .ev_vec({ev_bus_err, ev_arb_lost, ev_done_nostop, ev_done}));

// File: tb/i2c_buf_irq_tb.sv
module i2c_buf_irq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  tx_thresh = 4'd2, rx_thresh = 4'd3;
   logic        host_tx_push = 0, host_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
   logic [7:0]  host_tx_data = 0, eng_rx_data = 0;
   logic [7:0]  host_rx_data, eng_tx_data;
   logic        tx_flush_req = 0, rx_flush_req = 0, tx_flush_busy, rx_flush_busy;
   logic [4:0]  tx_level, rx_level;
   logic        ev_done = 0, ev_done_nostop = 0, ev_arb_lost = 0, ev_bus_err = 0;
   logic        mask_wr = 0, clr_wr = 0;
   logic [31:0] mask_wdata = 0, clr_wdata = 0;
   logic [31:0] mask_q, raw_status, masked_status;
   logic        irq;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #10 clk = ~clk;

   i2c_buf_irq u_dut (
      .clk(clk), .rst_n(rst_n), .tx_thresh(tx_thresh), .rx_thresh(rx_thresh),
      .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
      .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
      .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
      .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
      .tx_flush_req(tx_flush_req), .rx_flush_req(rx_flush_req),
      .tx_flush_busy(tx_flush_busy), .rx_flush_busy(rx_flush_busy),
      .tx_level(tx_level), .rx_level(rx_level),
      .ev_done(ev_done), .ev_done_nostop(ev_done_nostop),
      .ev_arb_lost(ev_arb_lost), .ev_bus_err(ev_bus_err),
      .mask_wr(mask_wr), .mask_wdata(mask_wdata), .mask_q(mask_q),
      .clr_wr(clr_wr), .clr_wdata(clr_wdata),
      .raw_status(raw_status), .masked_status(masked_status), .irq(irq));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // one edge, then drop every pulse input and sample away from the edge
   task automatic tick();
      @(posedge clk);
      #1;
      host_tx_push = 0; host_rx_pop = 0; eng_tx_pop = 0; eng_rx_push = 0;
      tx_flush_req = 0; rx_flush_req = 0; mask_wr = 0; clr_wr = 0;
      ev_done = 0; ev_done_nostop = 0; ev_arb_lost = 0; ev_bus_err = 0;
   endtask

   // op: 0 host TX push, 1 engine TX pop, 2 engine RX push, 3 host RX pop
   localparam int NVEC = 10;
   localparam logic [22:0] VEC [NVEC] = '{
      {2'd0, 8'hA1, 8'h00, 5'd1},
      {2'd0, 8'hB2, 8'h00, 5'd2},
      {2'd0, 8'hC3, 8'h00, 5'd3},
      {2'd1, 8'h00, 8'hA1, 5'd2},
      {2'd1, 8'h00, 8'hB2, 5'd1},
      {2'd2, 8'h5A, 8'h00, 5'd1},
      {2'd2, 8'h6B, 8'h00, 5'd2},
      {2'd2, 8'h7C, 8'h00, 5'd3},
      {2'd3, 8'h00, 8'h5A, 5'd2},
      {2'd1, 8'h00, 8'hC3, 5'd0}
   };

   always @(posedge clk) begin
      cyc++;
      if (cyc == 20000) begin
         errors++;
         $display("FAIL watchdog: actual=%0d expected=below %0d cycles", cyc, 20000);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R11 reset state
      check("R11 tx_level", 32'(tx_level), 0);
      check("R11 rx_level", 32'(rx_level), 0);
      check("R11 raw", raw_status, 32'h13);
      check("R11 mask", mask_q, 0);
      check("R11 irq", 32'(irq), 0);
      check("R11 busy", 32'({tx_flush_busy, rx_flush_busy}), 0);

      // table walk: R1 order, R2 live flags, R3 thresholds
      for (int i = 0; i < NVEC; i++) begin
         logic [1:0] op;
         logic [7:0] din, dexp;
         logic [4:0] lexp;
         {op, din, dexp, lexp} = VEC[i];
         case (op)
            2'd0: begin host_tx_data = din; host_tx_push = 1; end
            2'd1: begin check("R1 tx order", 32'(eng_tx_data), 32'(dexp)); eng_tx_pop = 1; end
            2'd2: begin eng_rx_data = din; eng_rx_push = 1; end
            default: begin check("R1 rx order", 32'(host_rx_data), 32'(dexp)); host_rx_pop = 1; end
         endcase
         tick();
         if (op < 2) begin
            check("R1 tx level", 32'(tx_level), 32'(lexp));
            check("R2/R3 tx flags", 32'(raw_status[2:0]),
                  32'({lexp == 5'd16, lexp <= 5'd2, lexp == 5'd0}));
         end else begin
            check("R1 rx level", 32'(rx_level), 32'(lexp));
            check("R2/R3 rx flags", 32'(raw_status[6:4]),
                  32'({lexp == 5'd16, lexp >= 5'd3, lexp == 5'd0}));
         end
      end

      // R9 / R10 mask and interrupt line; rx holds 2 entries
      mask_wr = 1; mask_wdata = 32'hFFFF_FFFF; tick();
      check("R9 mask reserved", mask_q, 32'h1FFF_FFFF);
      check("R10 masked", masked_status, 32'h03);
      check("R10 irq on", 32'(irq), 1);
      mask_wr = 1; mask_wdata = 32'h20; tick();
      check("R10 masked off", masked_status, 0);
      check("R10 irq off", 32'(irq), 0);
      eng_rx_data = 8'h8D; eng_rx_push = 1; tick();
      check("R3 rx threshold reached", 32'(raw_status[5]), 1);
      check("R10 masked rx", masked_status, 32'h20);
      check("R10 irq rx", 32'(irq), 1);
      check("R1 rx pop 1", 32'(host_rx_data), 32'h6B); host_rx_pop = 1; tick();
      check("R1 rx pop 2", 32'(host_rx_data), 32'h7C); host_rx_pop = 1; tick();
      check("R1 rx pop 3", 32'(host_rx_data), 32'h8D); host_rx_pop = 1; tick();
      host_rx_pop = 1; tick();
      check("R1 rx empty pop ignored", 32'(rx_level), 0);
      mask_wr = 1; mask_wdata = 0; tick();

      // R2 full, R4 overrun
      for (int i = 0; i < 16; i++) begin
         host_tx_data = 8'(16 + i); host_tx_push = 1; tick();
      end
      check("R2 tx full level", 32'(tx_level), 16);
      check("R2 tx full flags", 32'(raw_status[3:0]), 32'b0100);
      host_tx_data = 8'hEE; host_tx_push = 1; tick();
      check("R4 overrun level", 32'(tx_level), 16);
      check("R4 overrun bit", 32'(raw_status[3]), 1);
      for (int i = 0; i < 16; i++) begin
         check("R4 dropped byte absent", 32'(eng_tx_data), 32'(16 + i));
         eng_tx_pop = 1; tick();
      end
      check("R1 tx drained", 32'(tx_level), 0);
      check("R4 overrun sticky", 32'(raw_status[3]), 1);

      // R5 events
      ev_done = 1; ev_done_nostop = 1; ev_arb_lost = 1; ev_bus_err = 1; tick();
      check("R5 event bits", raw_status & 32'h131F_0000, 32'h1308_0000);
      tick();
      check("R5 event hold", raw_status & 32'h131F_0000, 32'h1308_0000);

      // R6 clear
      clr_wr = 1; clr_wdata = 32'h0100_0000; tick();
      check("R6 single clear", raw_status & 32'h131F_0008, 32'h1208_0008);
      ev_arb_lost = 1; clr_wr = 1; clr_wdata = 32'h0100_0000; tick();
      check("R6 set wins", 32'(raw_status[24]), 1);
      clr_wr = 1; clr_wdata = 32'hFFFF_FFFF; tick();
      check("R6 clear all keeps live bits", raw_status, 32'h13);

      // R7 / R8 TX flush
      for (int i = 0; i < 3; i++) begin
         host_tx_data = 8'(i); host_tx_push = 1; tick();
      end
      check("R7 pre-flush level", 32'(tx_level), 3);
      tx_flush_req = 1; tick();
      check("R7 flush busy 1", 32'(tx_flush_busy), 1);
      check("R7 flush empties", 32'(tx_level), 0);
      host_tx_data = 8'h55; host_tx_push = 1; eng_tx_pop = 1; tick();
      check("R8 push ignored", 32'(tx_level), 0);
      check("R7 flush busy 2", 32'(tx_flush_busy), 1);
      tick();
      check("R7 flush busy 3", 32'(tx_flush_busy), 1);
      tick();
      check("R7 flush busy 4", 32'(tx_flush_busy), 1);
      tick();
      check("R7 flush self-clears", 32'(tx_flush_busy), 0);
      host_tx_data = 8'h77; host_tx_push = 1; tick();
      check("R8 after flush level", 32'(tx_level), 1);
      check("R8 after flush data", 32'(eng_tx_data), 32'h77);
      eng_tx_pop = 1; tick();

      // R7 / R8 RX flush
      eng_rx_data = 8'h11; eng_rx_push = 1; tick();
      eng_rx_data = 8'h22; eng_rx_push = 1; tick();
      rx_flush_req = 1; tick();
      check("R7 rx flush empties", 32'(rx_level), 0);
      check("R7 rx busy", 32'(rx_flush_busy), 1);
      eng_rx_data = 8'h33; eng_rx_push = 1; host_rx_pop = 1; tick();
      check("R8 rx push ignored", 32'(rx_level), 0);
      repeat (3) tick();
      check("R7 rx busy clears", 32'(rx_flush_busy), 0);
      check("R2 final raw", raw_status, 32'h13);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule